// File: doc/BRIEF.md
# Shared-Block Fetch Grouping Scheduler

This block sits in front of a single-ported instruction cache that is shared by several thread contexts. Every cycle it looks at each context's next fetch PC, reduces it to a cache-block address and uses one of several selection policies to choose a single block to read. It then gathers every ready context that wants that same block into one fetch group, so one cache access can feed several instruction queues at once.

For each grouped context it works out the first instruction slot it needs in the block, the last slot it needs and the PC it will fetch from next. The last slot is either a predicted-taken branch or the end of the block. The result is an instruction-usage matrix with one row per instruction slot and one column per context. The fetch unit uses it to copy each fetched instruction into the right queues. Contexts that are left out of the group keep their PC. The cache array and the branch predictor are outside the block: branch predictions come in as inputs.

All outputs are registered. They appear one clock edge after the inputs are sampled.

Top module: `fgs_top`

## Requirements
- R1: While reset is high, every output is zero, and it stays zero through the first edge after reset.
- R2: A block address is the PC with its low 6 bits cleared (8 slots of 8 bytes). `fetch_blk` shows the selected block address one edge after the inputs are sampled, with `fetch_vld` high.
- R3: When no context is ready, `fetch_vld`, `grp_mask` and `usage` are all zero, and every `next_pc` lane equals that context's PC.
- R4: With `policy` equal to 0 or 3, the head context is selected if it is ready. Otherwise the first ready context in ring order after the head (head+1, head+2, and so on, modulo the number of contexts) is selected.
- R5: With `policy` equal to 1, the ready context with the numerically lowest block address is selected. A tie goes to the lowest context index.
- R6: With `policy` equal to 2, the ready context with the smallest `ctx_qcnt` is selected. A tie goes to the lowest context index.
- R7: `grp_mask` bit t is set exactly when context t is ready and its block address equals the selected block address.
- R8: `usage` bit (i*NCTX + t) is set exactly when context t is grouped and slot i lies from its offset (PC bits 5:3) up to and including its last slot.
- R9: A predicted-taken branch at a slot at or after the offset makes that slot the last slot. A branch slot below the offset is ignored, and the last slot is then 7.
- R10: For a grouped context, `next_pc` is `ctx_tgt` when its branch was honoured (R9), and otherwise the block address plus 64.
- R11: For a context that is not grouped, `next_pc` equals its current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Selection policy: 0/3 head-first, 1 lowest address, 2 fewest queued |
| head_idx | input | 2 | Index of the non-speculative head context |
| ctx_ready | input | NCTX | Per-context ready-to-fetch flag |
| ctx_pc | input | NCTX*PCW | Per-context next fetch PC, context t at bits t*PCW |
| ctx_qcnt | input | NCTX*QCW | Per-context instruction-queue occupancy |
| ctx_brk_vld | input | NCTX | Per-context predicted-taken branch present in the block |
| ctx_brk_slot | input | NCTX*3 | Slot of that predicted-taken branch |
| ctx_tgt | input | NCTX*PCW | Predicted branch target |
| fetch_vld | output | 1 | A block is being fetched this cycle |
| fetch_blk | output | PCW | Selected block address |
| grp_mask | output | NCTX | Contexts served by this fetch |
| usage | output | SLOTS*NCTX | Usage matrix, bit i*NCTX+t for slot i and context t |
| next_pc | output | NCTX*PCW | Updated PC for every context |

## Verification
The policies are tried on vectors where the head context is ready and where it is not. Some vectors have several contexts on the same block but at different offsets, which separates the ring walk from address order and occupancy order. Equal block addresses and equal queue counts expose the tie rules. Branch slots are placed before, at and after the offset, so an ignored branch can be told apart from an honoured one and from plain end-of-block. An all-idle vector and a batch of random vectors, drawn from a few shared blocks, cover the grouping and the PC hold of contexts left out of the group.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
    typedef enum logic [1:0] {
        POL_HEAD  = 2'd0,
        POL_ADDR  = 2'd1,
        POL_QOCC  = 2'd2,
        POL_HEADX = 2'd3
    } pol_e;

    function automatic int clog2i(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction
endpackage

// File: rtl/fgs_pick.sv
module fgs_pick import fgs_pkg::*; #(
    parameter int NCTX = 4,
    parameter int PCW  = 32,
    parameter int QCW  = 6,
    parameter int CIW  = 2
) (
    input  logic [1:0]          policy,
    input  logic [CIW-1:0]      head_idx,
    input  logic [NCTX-1:0]     ready,
    input  logic [NCTX*PCW-1:0] blk,
    input  logic [NCTX*QCW-1:0] qcnt,
    output logic                any,
    output logic [PCW-1:0]      sel_blk
);
    logic [CIW-1:0] sel;
    logic [PCW-1:0] best_a;
    logic [QCW-1:0] best_q;
    logic           found;

    always_comb begin
        sel    = '0;
        found  = 1'b0;
        best_a = '0;
        best_q = '0;
        any    = |ready;
        case (pol_e'(policy))
            POL_ADDR: begin
                for (int t = 0; t < NCTX; t++) begin
                    if (ready[t] && (!found || blk[t*PCW +: PCW] < best_a)) begin
                        best_a = blk[t*PCW +: PCW];
                        sel    = CIW'(t);
                        found  = 1'b1;
                    end
                end
            end
            POL_QOCC: begin
                for (int t = 0; t < NCTX; t++) begin
                    if (ready[t] && (!found || qcnt[t*QCW +: QCW] < best_q)) begin
                        best_q = qcnt[t*QCW +: QCW];
                        sel    = CIW'(t);
                        found  = 1'b1;
                    end
                end
            end
            default: begin
                for (int k = 0; k < NCTX; k++) begin
                    int j;
                    j = (int'(head_idx) + k) % NCTX;
                    if (ready[j] && !found) begin
                        sel   = CIW'(j);
                        found = 1'b1;
                    end
                end
            end
        endcase
        sel_blk = blk[int'(sel)*PCW +: PCW];
    end
endmodule

// File: rtl/fgs_lane.sv
module fgs_lane #(
    parameter int PCW   = 32,
    parameter int SLOTS = 8,
    parameter int IBYTE = 8,
    parameter int SLW   = 3,
    parameter int IBW   = 3,
    parameter int OFFW  = 6
) (
    input  logic             any,
    input  logic             ready,
    input  logic [PCW-1:0]   pc,
    input  logic             brk_vld,
    input  logic [SLW-1:0]   brk_slot,
    input  logic [PCW-1:0]   tgt,
    input  logic [PCW-1:0]   sel_blk,
    output logic [PCW-1:0]   blk,
    output logic             grp,
    output logic [SLOTS-1:0] col,
    output logic [PCW-1:0]   nxt
);
    localparam logic [PCW-1:0] BLK_BYTES = PCW'(SLOTS * IBYTE);

    logic [SLW-1:0] first_s;
    logic [SLW-1:0] last_s;
    logic           taken;

    assign blk     = {pc[PCW-1:OFFW], {OFFW{1'b0}}};
    assign first_s = pc[OFFW-1:IBW];
    assign taken   = brk_vld && (brk_slot >= first_s);
    assign last_s  = taken ? brk_slot : SLW'(SLOTS - 1);
    assign grp     = any && ready && (blk == sel_blk);

    always_comb begin
        for (int i = 0; i < SLOTS; i++)
            col[i] = grp && (SLW'(i) >= first_s) && (SLW'(i) <= last_s);
    end

    assign nxt = !grp ? pc : (taken ? tgt : blk + BLK_BYTES);
endmodule

// File: rtl/fgs_top.sv
module fgs_top import fgs_pkg::*; #(
    parameter int NCTX  = 4,
    parameter int PCW   = 32,
    parameter int QCW   = 6,
    parameter int SLOTS = 8,
    parameter int IBYTE = 8,
    localparam int CIW  = (NCTX > 1) ? clog2i(NCTX) : 1,
    localparam int SLW  = clog2i(SLOTS),
    localparam int IBW  = clog2i(IBYTE),
    localparam int OFFW = SLW + IBW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            policy,
    input  logic [CIW-1:0]        head_idx,
    input  logic [NCTX-1:0]       ctx_ready,
    input  logic [NCTX*PCW-1:0]   ctx_pc,
    input  logic [NCTX*QCW-1:0]   ctx_qcnt,
    input  logic [NCTX-1:0]       ctx_brk_vld,
    input  logic [NCTX*SLW-1:0]   ctx_brk_slot,
    input  logic [NCTX*PCW-1:0]   ctx_tgt,
    output logic                  fetch_vld,
    output logic [PCW-1:0]        fetch_blk,
    output logic [NCTX-1:0]       grp_mask,
    output logic [SLOTS*NCTX-1:0] usage,
    output logic [NCTX*PCW-1:0]   next_pc
);
    logic [NCTX*PCW-1:0]   blk_all;
    logic [NCTX*PCW-1:0]   nxt_all;
    logic [NCTX-1:0]       grp_all;
    logic [SLOTS*NCTX-1:0] use_all;
    logic [PCW-1:0]        sel_blk;
    logic                  any;

    fgs_pick #(.NCTX(NCTX), .PCW(PCW), .QCW(QCW), .CIW(CIW)) u_pick (
        .policy  (policy),
        .head_idx(head_idx),
        .ready   (ctx_ready),
        .blk     (blk_all),
        .qcnt    (ctx_qcnt),
        .any     (any),
        .sel_blk (sel_blk)
    );

    for (genvar t = 0; t < NCTX; t++) begin : g_lane
        logic [SLOTS-1:0] col;
        fgs_lane #(.PCW(PCW), .SLOTS(SLOTS), .IBYTE(IBYTE), .SLW(SLW),
                   .IBW(IBW), .OFFW(OFFW)) u_lane (
            .any     (any),
            .ready   (ctx_ready[t]),
            .pc      (ctx_pc[t*PCW +: PCW]),
            .brk_vld (ctx_brk_vld[t]),
            .brk_slot(ctx_brk_slot[t*SLW +: SLW]),
            .tgt     (ctx_tgt[t*PCW +: PCW]),
            .sel_blk (sel_blk),
            .blk     (blk_all[t*PCW +: PCW]),
            .grp     (grp_all[t]),
            .col     (col),
            .nxt     (nxt_all[t*PCW +: PCW])
        );
        for (genvar i = 0; i < SLOTS; i++) begin : g_row
            assign use_all[i*NCTX + t] = col[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_vld <= 1'b0;
            fetch_blk <= '0;
            grp_mask  <= '0;
            usage     <= '0;
            next_pc   <= '0;
        end else begin
            fetch_vld <= any;
            fetch_blk <= any ? sel_blk : '0;
            grp_mask  <= grp_all;
            usage     <= use_all;
            next_pc   <= nxt_all;
        end
    end

    a_r3_idle_empty: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |-> (grp_mask == '0 && usage == '0));
    a_r7_grp_ready: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((grp_mask & ~$past(ctx_ready)) == '0));
    a_r7_grp_nonempty: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> (grp_mask != '0));

    for (genvar t = 0; t < NCTX; t++) begin : g_chk
        a_r11_hold_pc: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && !grp_mask[t]) |->
                (next_pc[t*PCW +: PCW] == $past(ctx_pc[t*PCW +: PCW])));
        a_r8_first_slot: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && grp_mask[t]) |->
                usage[int'($past(ctx_pc[t*PCW+IBW +: SLW]))*NCTX + t]);
        a_r2_same_block: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && grp_mask[t]) |->
                (fetch_blk[PCW-1:OFFW] == $past(ctx_pc[t*PCW+OFFW +: PCW-OFFW])));
    end
endmodule

// File: tb/test_fgs_top.sv
module test_fgs_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int W = 32;
    localparam int Q = 6;
    localparam int S = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] policy;
    logic [1:0] head_idx;
    logic [N-1:0] ctx_ready;
    logic [N*W-1:0] ctx_pc, ctx_tgt;
    logic [N*Q-1:0] ctx_qcnt;
    logic [N-1:0] ctx_brk_vld;
    logic [N*3-1:0] ctx_brk_slot;
    logic fetch_vld;
    logic [W-1:0] fetch_blk;
    logic [N-1:0] grp_mask;
    logic [S*N-1:0] usage;
    logic [N*W-1:0] next_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    fgs_top i_fgs_top (
        .clk(clk), .rst(rst), .policy(policy), .head_idx(head_idx),
        .ctx_ready(ctx_ready), .ctx_pc(ctx_pc), .ctx_qcnt(ctx_qcnt),
        .ctx_brk_vld(ctx_brk_vld), .ctx_brk_slot(ctx_brk_slot), .ctx_tgt(ctx_tgt),
        .fetch_vld(fetch_vld), .fetch_blk(fetch_blk), .grp_mask(grp_mask),
        .usage(usage), .next_pc(next_pc)
    );

    typedef struct {
        logic           vld;
        logic [W-1:0]   blk;
        logic [N-1:0]   grp;
        logic [S*N-1:0] use_m;
        logic [N*W-1:0] nxt;
        string          tag;
    } exp_t;

    exp_t sb[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [W-1:0] b_pc [N];
    logic [W-1:0] b_tg [N];
    logic [Q-1:0] b_qc [N];
    logic [2:0]   b_bs [N];
    logic         b_bv [N];
    logic         b_rd [N];

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] pol, input logic [1:0] hd, input string tag);
        exp_t e;
        int sel;
        bit found;
        logic [W-1:0] blk [N];
        sel = 0; found = 0;
        for (int t = 0; t < N; t++) blk[t] = b_pc[t] & ~32'h3F;
        if (pol == 2'd1) begin
            for (int t = 0; t < N; t++)
                if (b_rd[t] && (!found || blk[t] < blk[sel])) begin sel = t; found = 1; end
        end else if (pol == 2'd2) begin
            for (int t = 0; t < N; t++)
                if (b_rd[t] && (!found || b_qc[t] < b_qc[sel])) begin sel = t; found = 1; end
        end else begin
            for (int k = 0; k < N; k++) begin
                int j;
                j = (int'(hd) + k) % N;
                if (b_rd[j] && !found) begin sel = j; found = 1; end
            end
        end
        e.vld = found;
        e.blk = found ? blk[sel] : '0;
        e.grp = '0; e.use_m = '0; e.nxt = '0;
        e.tag = tag;
        for (int t = 0; t < N; t++) begin
            int off, last;
            bit tk, g;
            off  = int'(b_pc[t][5:3]);
            tk   = b_bv[t] && int'(b_bs[t]) >= off;
            last = tk ? int'(b_bs[t]) : 7;
            g    = found && b_rd[t] && blk[t] == blk[sel];
            e.grp[t] = g;
            for (int i = 0; i < S; i++) e.use_m[i*N+t] = g && i >= off && i <= last;
            e.nxt[t*W +: W] = !g ? b_pc[t] : (tk ? b_tg[t] : blk[t] + 32'd64);
        end
        return e;
    endfunction

    task automatic drive(input logic [1:0] pol, input logic [1:0] hd, input string tag);
        @(negedge clk);
        policy = pol; head_idx = hd;
        for (int t = 0; t < N; t++) begin
            ctx_pc[t*W +: W]     = b_pc[t];
            ctx_tgt[t*W +: W]    = b_tg[t];
            ctx_qcnt[t*Q +: Q]   = b_qc[t];
            ctx_brk_slot[t*3 +: 3] = b_bs[t];
            ctx_brk_vld[t]       = b_bv[t];
            ctx_ready[t]         = b_rd[t];
        end
        sb.push_back(model(pol, hd, tag));
    endtask

    task automatic setc(int t, logic [W-1:0] pc, logic rd, logic [Q-1:0] qc,
                        logic bv, logic [2:0] bs, logic [W-1:0] tg);
        b_pc[t] = pc; b_rd[t] = rd; b_qc[t] = qc; b_bv[t] = bv; b_bs[t] = bs; b_tg[t] = tg;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check({e.tag, " R2 vld"}, 256'(fetch_vld), 256'(e.vld));
                check({e.tag, " R2 blk"}, 256'(fetch_blk), 256'(e.blk));
                check({e.tag, " R7 grp"}, 256'(grp_mask), 256'(e.grp));
                check({e.tag, " R8 usage"}, 256'(usage), 256'(e.use_m));
                check({e.tag, " R10/R11 next_pc"}, 256'(next_pc), 256'(e.nxt));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        policy = '0; head_idx = '0; ctx_ready = '0; ctx_pc = '0; ctx_tgt = '0;
        ctx_qcnt = '0; ctx_brk_vld = '0; ctx_brk_slot = '0;
        for (int t = 0; t < N; t++) setc(t, '0, 1'b0, '0, 1'b0, '0, '0);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 vld", 256'(fetch_vld), 256'(0));
        check("R1 grp", 256'(grp_mask), 256'(0));
        check("R1 usage", 256'(usage), 256'(0));
        check("R1 next_pc", 256'(next_pc), 256'(0));
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after release, R3 idle", 256'(fetch_vld), 256'(0));

        // R4: head ready, three share a block at different offsets
        setc(0, 32'h1000, 1, 6'd9, 0, 3'd0, 32'h0);
        setc(1, 32'h1010, 1, 6'd2, 0, 3'd0, 32'h0);
        setc(2, 32'h2000, 1, 6'd1, 0, 3'd0, 32'h0);
        setc(3, 32'h1038, 1, 6'd5, 0, 3'd0, 32'h0);
        drive(2'd0, 2'd0, "R4 head ready");
        // R4: head not ready, ring walk from head 2 picks 3
        b_rd[2] = 0;
        drive(2'd0, 2'd2, "R4 ring walk");
        // R4: policy 3 behaves as 0, head 1
        b_rd[2] = 1;
        drive(2'd3, 2'd1, "R4 policy3");
        // R5: lowest address; ties on 0x2000 blocks go to lower index
        setc(0, 32'h3000, 1, 6'd0, 0, 3'd0, 32'h0);
        setc(1, 32'h2008, 1, 6'd7, 0, 3'd0, 32'h0);
        setc(2, 32'h2030, 1, 6'd7, 0, 3'd0, 32'h0);
        setc(3, 32'h1000, 0, 6'd7, 0, 3'd0, 32'h0);
        drive(2'd1, 2'd0, "R5 lowest addr");
        // R6: fewest queued, tie between 1 and 3
        setc(0, 32'h4000, 1, 6'd8, 0, 3'd0, 32'h0);
        setc(1, 32'h5000, 1, 6'd3, 0, 3'd0, 32'h0);
        setc(2, 32'h6000, 0, 6'd0, 0, 3'd0, 32'h0);
        setc(3, 32'h5020, 1, 6'd3, 0, 3'd0, 32'h0);
        drive(2'd2, 2'd0, "R6 fewest queued");
        // R9/R10: branch after offset honoured, branch before offset ignored
        setc(0, 32'h7010, 1, 6'd0, 1, 3'd5, 32'h9000);
        setc(1, 32'h7028, 1, 6'd0, 1, 3'd2, 32'h9100);
        setc(2, 32'h7008, 1, 6'd0, 1, 3'd1, 32'h9200);
        setc(3, 32'h7000, 0, 6'd0, 1, 3'd0, 32'h9300);
        drive(2'd0, 2'd0, "R9 branch slots");
        // R3: nobody ready
        for (int t = 0; t < N; t++) b_rd[t] = 0;
        drive(2'd1, 2'd0, "R3 idle");
        // R7: random mix over a few shared blocks
        for (int r = 0; r < 40; r++) begin
            for (int t = 0; t < N; t++)
                setc(t, 32'h8000 + (($urandom % 3) << 6) + (($urandom % 8) << 3) + ($urandom % 8),
                     1'($urandom), 6'($urandom), 1'($urandom), 3'($urandom), 32'($urandom) & ~32'h7);
            drive(2'($urandom), 2'($urandom), "R7 random");
        end
        @(negedge clk);
        for (int t = 0; t < N; t++) b_rd[t] = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule